// File: doc/BRIEF.md
# Bounded Word Stack Pointer Unit

This block keeps the pointer of a stack of 32-bit words that lives in byte-addressed memory and grows toward lower addresses. The pointer always holds the address of the word currently on top. A client hands it push or pop operations over a valid/ready handshake. The block turns each accepted operation into one word access on a plain synchronous memory port. A push moves the pointer down by one word and then writes at the new address. A pop reads at the current address and then moves the pointer up by one word, once the memory completes the read.

Each operation is checked against two bounds before any access is made. These are an upper (top) address and a lower (bottom) address, both driven on input ports, so they can change at run time. An operation that would cross a bound makes no memory access and leaves the pointer alone. Instead it raises a one-cycle error pulse. The pointer value is always visible on a read-only output.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is held low and after reset, `sp_o` equals parameter `SP_INIT` (default 2000), `op_ready_o` is 1, and `mem_req_o`, `pop_valid_o`, `full_err_o` and `empty_err_o` are 0.
- R2: A push accepted while `sp_o` > `top_bound_i` lowers `sp_o` by 4 at the accepting edge. The next cycle issues a write (`mem_req_o`=1, `mem_we_o`=1) of the pushed data at the new `sp_o`.
- R3: A pop accepted while `sp_o` <= `bot_bound_i` issues a read (`mem_req_o`=1, `mem_we_o`=0) at the current `sp_o`. At the edge where `mem_ack_i` is seen, `sp_o` rises by 4 and `pop_data_o` takes the read word. In the following cycle `pop_valid_o` is high for exactly one cycle.
- R4: A push presented while `sp_o` <= `top_bound_i` is refused. `full_err_o` is high for exactly the cycle after acceptance, no memory request is made, and `sp_o` is unchanged.
- R5: A pop presented while `sp_o` > `bot_bound_i` is refused. `empty_err_o` is high for exactly the cycle after acceptance, no memory request is made, and `sp_o` is unchanged. At most one of `full_err_o`, `empty_err_o` and `pop_valid_o` is high in any cycle.
- R6: From an accepted operation until the edge where `mem_ack_i` completes it, `op_ready_o` is 0. An `op_valid_i` held high in that window starts no further operation.
- R7: While a memory request waits for `mem_ack_i`, `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stay unchanged.
- R8: Words come back from pops in the reverse of the order in which they were pushed.
- R9: The bound comparisons use the values present on `top_bound_i` and `bot_bound_i` in the accepting cycle, so a bound change affects the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| top_bound_i | input | AW | Push refused when pointer is at or below this |
| bot_bound_i | input | AW | Pop refused when pointer is above this |
| op_valid_i | input | 1 | Operation request |
| op_push_i | input | 1 | 1 = push, 0 = pop |
| op_wdata_i | input | DW | Word to push |
| op_ready_o | output | 1 | Unit idle and able to accept |
| pop_data_o | output | DW | Popped word |
| pop_valid_o | output | 1 | One-cycle strobe for `pop_data_o` |
| full_err_o | output | 1 | Refused push pulse |
| empty_err_o | output | 1 | Refused pop pulse |
| sp_o | output | AW | Current stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | DW | Write data |
| mem_ack_i | input | 1 | Access completes at this edge |
| mem_rdata_i | input | DW | Read data, valid with `mem_ack_i` |

## Verification
The hardest state to reach from the ports is the far edge of the address window. The push refusal only shows once the pointer has walked the whole span from the reset value down to the top bound. The stimulus pushes over a hundred words in a row until the refusal arrives, then pops some of them back to check their order. A stalled access with `op_valid_i` held high is produced by giving the memory model a multi-cycle latency. Bound changes at run time are made by moving a bound port onto the current pointer value just before an operation.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } stk_state_e;
endpackage

// File: rtl/stk_bound_chk.sv
module stk_bound_chk #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] top_bound_i,
  input  logic [AW-1:0] bot_bound_i,
  output logic          push_ok_o,
  output logic          pop_ok_o
);
  // pure compares, pointer untouched
  assign push_ok_o = sp_i > top_bound_i;
  assign pop_ok_o  = sp_i <= bot_bound_i;
endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int SP_INIT    = 2000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [AW-1:0] sp_o
);
  localparam logic [AW-1:0] STEP  = AW'(WORD_BYTES);
  localparam logic [AW-1:0] INITV = AW'(SP_INIT);

  logic [AW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= INITV;
    else if (dec_i) sp_q <= sp_q - STEP;
    else if (inc_i) sp_q <= sp_q + STEP;
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic          op_push_i,
  input  logic [DW-1:0] op_wdata_i,
  input  logic          push_ok_i,
  input  logic          pop_ok_i,
  input  logic [AW-1:0] sp_i,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          op_ready_o,
  output logic          sp_dec_o,
  output logic          sp_inc_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  output logic          full_err_o,
  output logic          empty_err_o
);
  stk_state_e state_q, state_d;
  logic [DW-1:0] wdata_q, pdata_q;
  logic pvalid_q, ferr_q, eerr_q;
  logic accept, do_push, do_pop, rd_done;

  assign op_ready_o = (state_q == ST_IDLE);
  assign accept     = op_valid_i && op_ready_o;
  assign do_push    = accept && op_push_i && push_ok_i;
  assign do_pop     = accept && !op_push_i && pop_ok_i;
  assign rd_done    = (state_q == ST_READ) && mem_ack_i;

  // pre-decrement on push, post-increment on pop completion
  assign sp_dec_o = do_push;
  assign sp_inc_o = rd_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (do_push)     state_d = ST_WRITE;
        else if (do_pop) state_d = ST_READ;
      end
      ST_WRITE: if (mem_ack_i) state_d = ST_IDLE;
      ST_READ:  if (mem_ack_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wdata_q  <= '0;
      pdata_q  <= '0;
      pvalid_q <= 1'b0;
      ferr_q   <= 1'b0;
      eerr_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (do_push) wdata_q <= op_wdata_i;
      if (rd_done) pdata_q <= mem_rdata_i;
      pvalid_q <= rd_done;
      ferr_q   <= accept && op_push_i && !push_ok_i;
      eerr_q   <= accept && !op_push_i && !pop_ok_i;
    end
  end

  // sp is stable for the whole access, so it doubles as the address
  assign mem_req_o   = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = sp_i;
  assign mem_wdata_o = wdata_q;
  assign pop_data_o  = pdata_q;
  assign pop_valid_o = pvalid_q;
  assign full_err_o  = ferr_q;
  assign empty_err_o = eerr_q;
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int WORD_BYTES = 4,
  parameter int SP_INIT    = 2000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] top_bound_i,
  input  logic [AW-1:0] bot_bound_i,
  input  logic          op_valid_i,
  input  logic          op_push_i,
  input  logic [DW-1:0] op_wdata_i,
  output logic          op_ready_o,
  output logic [DW-1:0] pop_data_o,
  output logic          pop_valid_o,
  output logic          full_err_o,
  output logic          empty_err_o,
  output logic [AW-1:0] sp_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic push_ok, pop_ok, sp_dec, sp_inc;
  logic [AW-1:0] sp;

  stk_bound_chk #(.AW(AW)) u_bound (
    .sp_i        (sp),
    .top_bound_i (top_bound_i),
    .bot_bound_i (bot_bound_i),
    .push_ok_o   (push_ok),
    .pop_ok_o    (pop_ok)
  );

  stk_sp_reg #(.AW(AW), .WORD_BYTES(WORD_BYTES), .SP_INIT(SP_INIT)) u_sp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (sp_dec),
    .inc_i  (sp_inc),
    .sp_o   (sp)
  );

  stk_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_valid_i  (op_valid_i),
    .op_push_i   (op_push_i),
    .op_wdata_i  (op_wdata_i),
    .push_ok_i   (push_ok),
    .pop_ok_i    (pop_ok),
    .sp_i        (sp),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .op_ready_o  (op_ready_o),
    .sp_dec_o    (sp_dec),
    .sp_inc_o    (sp_inc),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .pop_data_o  (pop_data_o),
    .pop_valid_o (pop_valid_o),
    .full_err_o  (full_err_o),
    .empty_err_o (empty_err_o)
  );

  assign sp_o = sp;
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] top_bound_i,
  input logic [AW-1:0] bot_bound_i,
  input logic          op_valid_i,
  input logic          op_push_i,
  input logic          op_ready_o,
  input logic          pop_valid_o,
  input logic          full_err_o,
  input logic          empty_err_o,
  input logic [AW-1:0] sp_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  a_r2_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_ready_o && op_push_i && (sp_o > top_bound_i)
    |=> (sp_o == $past(sp_o) - STEP) && mem_req_o && mem_we_o);

  a_r3_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i
    |=> pop_valid_o && (sp_o == $past(sp_o) + STEP));

  a_r4_full_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_ready_o && op_push_i && (sp_o <= top_bound_i)
    |=> full_err_o && !mem_req_o && $stable(sp_o));

  a_r5_empty_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_ready_o && !op_push_i && (sp_o > bot_bound_i)
    |=> empty_err_o && !mem_req_o && $stable(sp_o));

  a_r5_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({full_err_o, empty_err_o, pop_valid_o}));

  a_r6_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !op_ready_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i
    |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(.AW(AW), .WORD_BYTES(WORD_BYTES)) chk_i (.*);

// File: tb/stack_ptr_unit_tb_top.sv
module stack_ptr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] top_b = 32'd1500;
  logic [31:0] bot_b = 32'd2000;
  logic        op_valid = 1'b0;
  logic        op_push = 1'b0;
  logic [31:0] op_wdata = '0;
  logic        op_ready, pop_valid, full_err, empty_err;
  logic [31:0] pop_data, sp;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int total = 0;
  int bad = 0;
  int lat = 1;
  int cnt = 0;
  logic [31:0] mem [256];
  logic [31:0] model_mem [256];
  logic [31:0] model_sp = 32'd2000;
  logic [31:0] exp_q [$];

  always #10 clk = ~clk;

  stack_ptr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .top_bound_i(top_b), .bot_bound_i(bot_b),
    .op_valid_i(op_valid), .op_push_i(op_push), .op_wdata_i(op_wdata),
    .op_ready_o(op_ready), .pop_data_o(pop_data), .pop_valid_o(pop_valid),
    .full_err_o(full_err), .empty_err_o(empty_err), .sp_o(sp),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic int widx(input logic [31:0] a);
    return int'(a[9:2]);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory model with configurable latency
  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'hA000_0000 + 32'(i * 7);
      model_mem[i] = 32'hA000_0000 + 32'(i * 7);
    end
    forever begin
      @(posedge clk);
      if (mem_req && !mem_ack) begin
        if (cnt == lat - 1) begin
          mem_ack <= 1'b1;
          if (mem_we) mem[widx(mem_addr)] = mem_wdata;
          else mem_rdata <= mem[widx(mem_addr)];
          cnt = 0;
        end else cnt = cnt + 1;
      end else mem_ack <= 1'b0;
    end
  end

  // scoreboard monitor: R3 strobe/data, R8 LIFO order
  initial begin
    forever begin
      @(negedge clk);
      if (pop_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected pop_valid", pop_data, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(pop_data == e, "R8 pop order/data", pop_data, e);
        end
      end
    end
  end

  task automatic wait_ready();
    do @(negedge clk); while (!op_ready);
  endtask

  task automatic do_push(input logic [31:0] d);
    bit ok;
    wait_ready();
    ok = model_sp > top_b;
    op_valid = 1'b1; op_push = 1'b1; op_wdata = d;
    @(negedge clk);
    op_valid = 1'b0;
    if (ok) begin
      model_sp = model_sp - 32'd4;
      model_mem[widx(model_sp)] = d;
      chk(mem_req && mem_we && !full_err, "R2 write issued", {31'd0, mem_req}, 1);
      chk(mem_addr == model_sp, "R2 write address", mem_addr, model_sp);
      chk(mem_wdata == d, "R2 write data", mem_wdata, d);
    end else begin
      chk(full_err && !mem_req, "R4 full pulse, no access", {31'd0, full_err}, 1);
      chk(sp == model_sp, "R4 sp unchanged", sp, model_sp);
    end
    wait_ready();
    chk(!full_err, "R4 pulse one cycle", {31'd0, full_err}, 0);
    chk(sp == model_sp, "R2 sp after push", sp, model_sp);
  endtask

  task automatic do_pop();
    bit ok;
    wait_ready();
    ok = model_sp <= bot_b;
    op_valid = 1'b1; op_push = 1'b0;
    @(negedge clk);
    op_valid = 1'b0;
    if (ok) begin
      chk(mem_req && !mem_we, "R3 read issued", {31'd0, mem_req}, 1);
      chk(mem_addr == model_sp, "R3 read address", mem_addr, model_sp);
      exp_q.push_back(model_mem[widx(model_sp)]);
      model_sp = model_sp + 32'd4;
    end else begin
      chk(empty_err && !mem_req, "R5 empty pulse, no access", {31'd0, empty_err}, 1);
      chk(sp == model_sp, "R5 sp unchanged", sp, model_sp);
    end
    wait_ready();
    chk(!empty_err, "R5 pulse one cycle", {31'd0, empty_err}, 0);
    chk(sp == model_sp, "R3 sp after pop", sp, model_sp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sp == 32'd2000, "R1 sp reset", sp, 2000);
    chk(op_ready && !mem_req && !pop_valid && !full_err && !empty_err,
        "R1 idle outputs", {31'd0, op_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp == 32'd2000 && op_ready, "R1 after release", sp, 2000);

    // R2/R3/R8 short LIFO run
    do_push(32'h1111_0001);
    do_push(32'h2222_0002);
    do_push(32'h3333_0003);
    do_pop(); do_pop(); do_pop();
    // at bottom bound: one pop still allowed, then refused (R5)
    do_pop();
    do_pop();
    do_push(32'h4444_0004);

    // fill down to the top bound until a push is refused (R4)
    while (model_sp > top_b) do_push(32'h5500_0000 + model_sp);
    do_push(32'hDEAD_0001);
    do_push(32'hDEAD_0002);
    repeat (5) do_pop();

    // R6/R7: stalled access with valid held high
    lat = 3;
    begin
      logic [31:0] a0;
      wait_ready();
      op_valid = 1'b1; op_push = 1'b1; op_wdata = 32'h7777_0007;
      @(negedge clk);
      chk(!op_ready, "R6 ready low while busy", {31'd0, op_ready}, 0);
      a0 = mem_addr;
      @(negedge clk);
      chk(!op_ready, "R6 ready still low", {31'd0, op_ready}, 0);
      chk(mem_req && mem_addr == a0 && mem_we, "R7 request held", mem_addr, a0);
      op_valid = 1'b0;
      model_sp = model_sp - 32'd4;
      model_mem[widx(model_sp)] = 32'h7777_0007;
      wait_ready();
      chk(sp == model_sp, "R6 single acceptance", sp, model_sp);
    end
    do_pop();
    lat = 1;

    // R9: bounds moved at run time
    top_b = model_sp;
    do_push(32'hBEEF_0009);
    top_b = 32'd1500;
    bot_b = model_sp - 32'd4;
    do_pop();
    bot_b = 32'd2000;
    do_pop();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all pops returned", exp_q.size(), 0);
    finish_run();
  end
endmodule